// File: doc/BRIEF.md
# Hardware-Gated Period Timer with Capture

This block is an up-counter with a period value. One external control line can start it, clear it and halt it with no software action. The line passes through a two-flop synchronizer, and edges are found by comparing the synchronized value with its value one clock earlier. A polarity input selects which level counts as active. For the rules that distinguish edge directions, it also selects which transition counts as active. Three independent 2-bit selects pick the start rule, the clear rule and the halt rule. Each select has four codes.

The block reports the live count, a RUN status and a level output that follows RUN. It also holds a capture register with a one-clock capture strobe. The capture path is a plain strobe with no back-pressure. The register holds the last captured value until the next capture overwrites it, and nothing waits for the value to be read. A software enable gates the whole block. When it is low, the count freezes and RUN drops.

Top module: `gated_timer`

## Requirements
- R1: While `on_i` is low, the count holds its value and `run_o` and `level_o` read 0. When a clock edge samples `on_i` low, `run_o` reads 0 after that edge.
- R2: With `start_sel_i`=0 (free), the timer arms on the first clock that samples `on_i` high and counts from the next clock on. A later hardware halt keeps it stopped until `on_i` is lowered and raised again.
- R3: With `start_sel_i`=1, any transition of the synchronized line arms the timer. Polarity has no effect. A change on `ext_i` acts on the third rising clock edge after it.
- R4: With `start_sel_i`=2, only the active transition arms the timer. The active transition is rising for `pol_i`=0 and falling for `pol_i`=1. The opposite transition does nothing.
- R5: With `start_sel_i`=3, the timer counts only on clocks where the synchronized line is at its active level (high for `pol_i`=0, low for `pol_i`=1). Otherwise it holds.
- R6: With `clr_sel_i`=1, the count is held at 0 on every clock where the synchronized line is at its inactive level. During those clocks `run_o` and `level_o` read 0. Counting resumes once the active level returns.
- R7: With `clr_sel_i` set to 1, 2 or 3, a running count that equals `period_i` goes to 0 on the next clock, and `run_o` stays 1.
- R8: With `clr_sel_i`=2, the count is cleared on the clock where the timer is armed. `run_o` stays 1.
- R9: With `clr_sel_i`=0, hardware never clears the count, and it counts on past `period_i`.
- R10: With `halt_sel_i`=0, only `on_i` stops the timer. A capture still happens on each active transition of the line, while the timer keeps running.
- R11: With `halt_sel_i`=1 (any transition) or 2 (active transition), the transition halts counting and captures the count.
- R12: With `halt_sel_i`=3, a running count equal to `period_i` halts on the next clock and is captured.
- R13: If a start and a halt condition happen on the same clock, the timer stays halted.
- R14: A capture loads the count from before that clock's update into `cap_o` and pulses `cap_stb_o` for exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| on_i | input | 1 | Software enable |
| ext_i | input | 1 | Asynchronous external control line |
| pol_i | input | 1 | 0: high level / rising transition is active; 1: low / falling |
| start_sel_i | input | 2 | 0 free, 1 any transition, 2 active transition, 3 active level |
| clr_sel_i | input | 2 | 0 none, 1 inactive level + period, 2 at arming + period, 3 period |
| halt_sel_i | input | 2 | 0 none, 1 any transition, 2 active transition, 3 period |
| period_i | input | WIDTH | Period value |
| count_o | output | WIDTH | Current count |
| run_o | output | 1 | Timer running |
| level_o | output | 1 | Level output, follows RUN |
| cap_o | output | WIDTH | Last captured count |
| cap_stb_o | output | 1 | One-clock capture strobe |

## Verification
The hardest case to reach from the ports is a start and a halt landing on the same synchronized edge. This case is paired with the clear-at-arming rule, because that clear only shows up once a halted, non-zero count is armed again. The stimulus selects start on any transition and halt on the active transition. A rising step on the line then triggers both rules together and must leave the timer halted. A falling step re-arms it. A second rising step halts it at a known count, and the final falling step must restart the count from zero. Every step is timed against the three-clock synchronizer latency.

// File: rtl/gt_pkg.sv
package gt_pkg;
  typedef enum logic [1:0] {
    START_FREE      = 2'd0,
    START_ANY_EDGE  = 2'd1,
    START_ACT_EDGE  = 2'd2,
    START_ACT_LEVEL = 2'd3
  } start_sel_e;

  typedef enum logic [1:0] {
    CLR_NONE        = 2'd0,
    CLR_IDLE_LVL_PM = 2'd1,
    CLR_ARM_PM      = 2'd2,
    CLR_PM          = 2'd3
  } clr_sel_e;

  typedef enum logic [1:0] {
    HALT_NONE     = 2'd0,
    HALT_ANY_EDGE = 2'd1,
    HALT_ACT_EDGE = 2'd2,
    HALT_PM       = 2'd3
  } halt_sel_e;
endpackage

// File: rtl/gt_edge_sync.sv
module gt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  input  logic pol_i,
  output logic act_lvl_o,
  output logic any_edge_o,
  output logic act_edge_o
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;
  logic          prev_q;
  logic          synced;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[LAST-1:0], async_i};
      prev_q  <= chain_q[LAST];
    end
  end

  assign synced     = chain_q[LAST];
  assign act_lvl_o  = synced ^ pol_i;
  assign any_edge_o = synced ^ prev_q;
  assign act_edge_o = act_lvl_o & ~(prev_q ^ pol_i);
endmodule

// File: rtl/gt_ctrl.sv
module gt_ctrl
  import gt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       on_i,
  input  start_sel_e start_sel,
  input  clr_sel_e   clr_sel,
  input  halt_sel_e  halt_sel,
  input  logic       act_lvl,
  input  logic       any_edge,
  input  logic       act_edge,
  input  logic       at_period,
  output logic       run_o,
  output logic       inc_o,
  output logic       clear_o,
  output logic       cap_ev_o
);
  logic run_q, on_q;
  logic start_ev, halt_ev, match, lvl_clear, arm_clear, pm_clear, cap_raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) on_q <= 1'b0;
    else        on_q <= on_i;
  end

  always_comb begin
    unique case (start_sel)
      START_FREE:      start_ev = on_i & ~on_q;
      START_ANY_EDGE:  start_ev = any_edge;
      START_ACT_EDGE:  start_ev = act_edge;
      default:         start_ev = act_lvl;
    endcase
  end

  assign match = run_q & at_period;

  always_comb begin
    unique case (halt_sel)
      HALT_NONE:     begin halt_ev = 1'b0;     cap_raw = act_edge; end
      HALT_ANY_EDGE: begin halt_ev = any_edge; cap_raw = any_edge; end
      HALT_ACT_EDGE: begin halt_ev = act_edge; cap_raw = act_edge; end
      default:       begin halt_ev = match;    cap_raw = match;    end
    endcase
  end

  assign lvl_clear = on_i & (clr_sel == CLR_IDLE_LVL_PM) & ~act_lvl;
  assign arm_clear = (clr_sel == CLR_ARM_PM) & start_ev & ~run_q & ~halt_ev;
  assign pm_clear  = (clr_sel != CLR_NONE) & match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             run_q <= 1'b0;
    else if (!on_i)                         run_q <= 1'b0;
    else if (halt_ev)                       run_q <= 1'b0;
    else if (start_sel == START_ACT_LEVEL)  run_q <= act_lvl;
    else if (start_ev)                      run_q <= 1'b1;
  end

  assign run_o    = run_q & ~lvl_clear;
  assign inc_o    = on_i & run_q & ~halt_ev;
  assign clear_o  = on_i & (lvl_clear | arm_clear | pm_clear);
  assign cap_ev_o = on_i & cap_raw;
endmodule

// File: rtl/gt_counter.sv
module gt_counter #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             inc_i,
  input  logic             cap_ev_i,
  output logic [WIDTH-1:0] count_o,
  output logic [WIDTH-1:0] cap_o,
  output logic             cap_stb_o
);
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [WIDTH-1:0] count_q, cap_q;
  logic             stb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count_q <= '0;
    else if (clear_i) count_q <= '0;
    else if (inc_i)   count_q <= count_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= '0;
      stb_q <= 1'b0;
    end else begin
      stb_q <= cap_ev_i;
      if (cap_ev_i) cap_q <= count_q;
    end
  end

  assign count_o   = count_q;
  assign cap_o     = cap_q;
  assign cap_stb_o = stb_q;
endmodule

// File: rtl/gated_timer.sv
module gated_timer
  import gt_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             on_i,
  input  logic             ext_i,
  input  logic             pol_i,
  input  logic [1:0]       start_sel_i,
  input  logic [1:0]       clr_sel_i,
  input  logic [1:0]       halt_sel_i,
  input  logic [WIDTH-1:0] period_i,
  output logic [WIDTH-1:0] count_o,
  output logic             run_o,
  output logic             level_o,
  output logic [WIDTH-1:0] cap_o,
  output logic             cap_stb_o
);
  logic act_lvl, any_edge, act_edge, at_period;
  logic inc, clear, cap_ev, run;

  gt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(ext_i), .pol_i(pol_i),
    .act_lvl_o(act_lvl), .any_edge_o(any_edge), .act_edge_o(act_edge)
  );

  gt_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .on_i(on_i),
    .start_sel(start_sel_e'(start_sel_i)),
    .clr_sel(clr_sel_e'(clr_sel_i)),
    .halt_sel(halt_sel_e'(halt_sel_i)),
    .act_lvl(act_lvl), .any_edge(any_edge), .act_edge(act_edge),
    .at_period(at_period),
    .run_o(run), .inc_o(inc), .clear_o(clear), .cap_ev_o(cap_ev)
  );

  gt_counter #(.WIDTH(WIDTH)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clear_i(clear), .inc_i(inc),
    .cap_ev_i(cap_ev), .count_o(count_o), .cap_o(cap_o),
    .cap_stb_o(cap_stb_o)
  );

  assign at_period = (count_o == period_i);
  assign run_o     = run;
  assign level_o   = run;
endmodule

// File: rtl/gt_checker.sv
module gt_checker #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             on_i,
  input logic [1:0]       clr_sel_i,
  input logic [1:0]       halt_sel_i,
  input logic [WIDTH-1:0] period_i,
  input logic [WIDTH-1:0] count_o,
  input logic             run_o,
  input logic [WIDTH-1:0] cap_o,
  input logic             cap_stb_o
);
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  p_off_freezes_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !on_i |=> (count_o == $past(count_o)) && !run_o);

  p_period_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (on_i && clr_sel_i != 2'd0 && run_o && count_o == period_i) |=> count_o == '0);

  p_period_halt_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (on_i && halt_sel_i == 2'd3 && run_o && count_o == period_i) |=> (!run_o && cap_stb_o));

  p_cap_value_r14: assert property (@(posedge clk) disable iff (!rst_n)
    cap_stb_o |-> cap_o == $past(count_o));

  p_unit_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    on_i |=> (count_o == '0) || (count_o == $past(count_o)) || (count_o == $past(count_o) + ONE));
endmodule

bind gated_timer gt_checker #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .on_i(on_i), .clr_sel_i(clr_sel_i),
  .halt_sel_i(halt_sel_i), .period_i(period_i), .count_o(count_o),
  .run_o(run_o), .cap_o(cap_o), .cap_stb_o(cap_stb_o)
);

// File: tb/tb_gated_timer.sv
`timescale 1ns/1ps
module tb_gated_timer;
  localparam int W = 16;
  logic clk = 1'b0, rst_n = 1'b0, on_i = 1'b0, ext_i = 1'b0, pol_i = 1'b0;
  logic [1:0] start_sel = 2'd0, clr_sel = 2'd0, halt_sel = 2'd0;
  logic [W-1:0] period = '0;
  logic [W-1:0] count, cap;
  logic run, level, cap_stb;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gated_timer #(.WIDTH(W)) dut (
    .clk(clk), .rst_n(rst_n), .on_i(on_i), .ext_i(ext_i), .pol_i(pol_i),
    .start_sel_i(start_sel), .clr_sel_i(clr_sel), .halt_sel_i(halt_sel),
    .period_i(period), .count_o(count), .run_o(run), .level_o(level),
    .cap_o(cap), .cap_stb_o(cap_stb)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic setup(input logic [1:0] st, input logic [1:0] cl, input logic [1:0] ht,
                       input logic pol, input logic ext, input int per);
    @(negedge clk);
    rst_n = 1'b0; on_i = 1'b0;
    start_sel = st; clr_sel = cl; halt_sel = ht;
    pol_i = pol; ext_i = ext; period = W'(per);
    tick(2);
    rst_n = 1'b1;
    tick(4);
  endtask

  task automatic t_reset_state;
    setup(2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 10);
    chk("R1 reset count", count, 0);
    chk("R1 reset run", run, 0);
    chk("R1 reset level", level, 0);
    chk("R14 reset strobe", cap_stb, 0);
  endtask

  task automatic t_free_and_off;
    setup(2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 5);
    on_i = 1'b1;
    tick(10);
    chk("R2 free run count", count, 9);
    chk("R9 count past period", count > 5, 1);
    chk("R2 level follows run", level, 1);
    on_i = 1'b0;
    tick(1);
    chk("R1 off run", run, 0);
    tick(3);
    chk("R1 off freezes count", count, 9);
    on_i = 1'b1;
    tick(2);
    chk("R2 rearm on enable", count, 10);
  endtask

  task automatic t_period_clear;
    for (int s = 1; s <= 3; s++) begin
      setup(2'd0, 2'(s), 2'd0, 1'b0, 1'b1, 3);
      on_i = 1'b1;
      tick(4);
      chk("R7 count reaches period", count, 3);
      tick(1);
      chk("R7 cleared after period", count, 0);
      chk("R7 run stays", run, 1);
    end
  endtask

  task automatic t_level_clear;
    setup(2'd0, 2'd1, 2'd0, 1'b0, 1'b1, 100);
    on_i = 1'b1;
    tick(6);
    chk("R6 counting at active level", count, 5);
    ext_i = 1'b0;
    tick(3);
    chk("R6 held at zero", count, 0);
    chk("R6 run forced low", run, 0);
    chk("R6 level forced low", level, 0);
    tick(2);
    chk("R6 still zero", count, 0);
    ext_i = 1'b1;
    tick(4);
    chk("R6 resumes", count, 2);
    chk("R6 run back", run, 1);
  endtask

  task automatic t_start_any;
    setup(2'd1, 2'd0, 2'd0, 1'b1, 1'b0, 100);
    on_i = 1'b1;
    tick(4);
    chk("R3 idle before edge", run, 0);
    ext_i = 1'b1;
    tick(3);
    chk("R3 armed by transition", run, 1);
    chk("R3 count at arm", count, 0);
    tick(2);
    chk("R3 counting", count, 2);
  endtask

  task automatic t_start_act_edge;
    setup(2'd2, 2'd0, 2'd0, 1'b1, 1'b0, 100);
    on_i = 1'b1;
    ext_i = 1'b1;
    tick(6);
    chk("R4 rising ignored with pol=1", run, 0);
    chk("R4 count unchanged", count, 0);
    ext_i = 1'b0;
    tick(3);
    chk("R4 falling arms with pol=1", run, 1);
    tick(3);
    chk("R4 counting", count, 3);
  endtask

  task automatic t_start_level;
    setup(2'd3, 2'd0, 2'd0, 1'b0, 1'b0, 100);
    on_i = 1'b1;
    tick(4);
    chk("R5 idle at inactive level", run, 0);
    ext_i = 1'b1;
    tick(3);
    chk("R5 runs at active level", run, 1);
    tick(3);
    chk("R5 count", count, 3);
    ext_i = 1'b0;
    tick(3);
    chk("R5 stops at inactive level", run, 0);
    chk("R5 count at stop", count, 6);
    tick(3);
    chk("R5 count holds", count, 6);
  endtask

  task automatic t_arm_clear_and_tie;
    setup(2'd1, 2'd2, 2'd2, 1'b0, 1'b0, 100);
    on_i = 1'b1;
    tick(2);
    ext_i = 1'b1;
    tick(3);
    chk("R13 halt wins over start", run, 0);
    tick(3);
    chk("R13 count stays", count, 0);
    ext_i = 1'b0;
    tick(3);
    chk("R8 armed on falling", run, 1);
    tick(5);
    chk("R8 counting", count, 5);
    ext_i = 1'b1;
    tick(3);
    chk("R11 active-edge halt run", run, 0);
    chk("R11 halted count", count, 7);
    chk("R14 strobe", cap_stb, 1);
    chk("R14 captured value", cap, 7);
    tick(1);
    chk("R14 strobe one clock", cap_stb, 0);
    ext_i = 1'b0;
    tick(3);
    chk("R8 cleared at arming", count, 0);
    chk("R8 run stays", run, 1);
  endtask

  task automatic t_halt_period;
    setup(2'd0, 2'd0, 2'd3, 1'b0, 1'b0, 4);
    on_i = 1'b1;
    tick(6);
    chk("R12 halted after period", run, 0);
    chk("R12 count held", count, 4);
    chk("R12 capture strobe", cap_stb, 1);
    chk("R12 capture value", cap, 4);
    tick(3);
    chk("R12 stays halted", count, 4);
  endtask

  task automatic t_cap_none;
    int seen;
    setup(2'd0, 2'd0, 2'd0, 1'b1, 1'b1, 100);
    on_i = 1'b1;
    tick(6);
    ext_i = 1'b0;
    tick(3);
    chk("R10 capture on active edge", cap_stb, 1);
    chk("R10 captured value", cap, 7);
    chk("R10 keeps running", run, 1);
    chk("R10 count advanced", count, 8);
    ext_i = 1'b1;
    seen = 0;
    for (int i = 0; i < 6; i++) begin
      tick(1);
      if (cap_stb) seen++;
    end
    chk("R10 no capture on inactive edge", seen, 0);
    chk("R10 capture held", cap, 7);
  endtask

  task automatic t_halt_any;
    setup(2'd0, 2'd0, 2'd1, 1'b0, 1'b0, 100);
    on_i = 1'b1;
    tick(4);
    chk("R11 count before", count, 3);
    ext_i = 1'b1;
    tick(3);
    chk("R11 any-edge halt", run, 0);
    chk("R11 capture", cap, 5);
    chk("R11 strobe", cap_stb, 1);
    ext_i = 1'b0;
    tick(3);
    chk("R11 second transition captures", cap_stb, 1);
    chk("R2 stays halted", run, 0);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      done = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_free_and_off();
    t_period_clear();
    t_level_clear();
    t_start_any();
    t_start_act_edge();
    t_start_level();
    t_arm_clear_and_tie();
    t_halt_period();
    t_cap_none();
    t_halt_any();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule